// File: doc/BRIEF.md
# VGA RGB565 Display Timing Controller

This block is the pixel timing engine for a 640x480, 60 Hz raster display. It keeps a horizontal and a vertical position and from them derives active-low horizontal and vertical sync, a data-enable flag, and the 8-bit red, green and blue outputs. During the visible area it consumes one 16-bit RGB565 pixel per clock from a line buffer stage that presents its data ahead of the read strobe, and it expands the pixel to 24-bit colour in the same cycle.

Two line buffers feed the block in turns. The controller owns the swap. A one-clock line-advance pulse follows the last visible pixel of each visible line, and a buffer-select output then flips so the drained buffer can refill while the other one is shown. A one-clock frame-start pulse marks the first pixel of every frame.

Each axis runs the same four-state machine, and each state lasts for a parameter-set count. The states are ACTIVE (visible), FRONT (front porch), SYNC (sync pulse) and BACK (back porch). The transitions are ACTIVE->FRONT, FRONT->SYNC, SYNC->BACK and BACK->ACTIVE, each taken on the last count of the state. The horizontal machine steps on every clock. The vertical machine steps only when the horizontal machine wraps from BACK to ACTIVE.

Top module: `vga565_timing`

## Requirements
- R1: While reset is low and in the first cycle after it is released, both counters sit at the frame origin. In that state de=1, pix_rd=1, hsync_n=1, vsync_n=1, frame_start=1, line_adv=0 and buf_sel=0.
- R2: A line lasts H_ACTIVE+H_FRONT+H_SYNC+H_BACK clocks. With h as the position in the line from 0, de can be high only for h < H_ACTIVE. hsync_n is 0 exactly for H_ACTIVE+H_FRONT <= h < H_ACTIVE+H_FRONT+H_SYNC.
- R3: A frame lasts V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines. With v as the line index from 0, de is high exactly when h < H_ACTIVE and v < V_ACTIVE. vsync_n is 0 for whole lines V_ACTIVE+V_FRONT <= v < V_ACTIVE+V_FRONT+V_SYNC, and changes only at h=0.
- R4: pix_rd is high exactly in the cycles where de is high, so it pulses H_ACTIVE times in each visible line and never in a blanking line.
- R5: While de=1, red={pix_in[15:11],pix_in[15:13]}, green={pix_in[10:5],pix_in[10:9]} and blue={pix_in[4:0],pix_in[4:2]}, taken from pix_in in the same cycle.
- R6: While de=0, red, green and blue are all 0.
- R7: line_adv is a one-clock pulse at h=H_ACTIVE of every visible line, the cycle right after the last de cycle. It never occurs in blanking lines.
- R8: buf_sel flips at the clock edge that ends each line_adv cycle and holds its value otherwise. Value 0 selects the first line buffer as the pixel source.
- R9: frame_start is a one-clock pulse at h=0, v=0 and repeats once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_in | input | 16 | RGB565 pixel presented by the selected line buffer |
| pix_rd | output | 1 | Pixel consume strobe to the selected line buffer |
| buf_sel | output | 1 | Line buffer currently feeding pixels (0 = first) |
| line_adv | output | 1 | One-clock pulse after the last visible pixel of a line |
| frame_start | output | 1 | One-clock pulse on the first pixel of a frame |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Visible-area data enable |
| red | output | 8 | Expanded red channel |
| green | output | 8 | Expanded green channel |
| blue | output | 8 | Expanded blue channel |

## Verification
Sync, de, pix_rd, line_adv and frame_start are decoded from the position registers, so each one is due in the cycle that the position reaches the value given in its requirement. Colour follows pix_in within that same cycle. buf_sel is the only registered output, and it is due one cycle after line_adv. The bench keeps its own cycle index from reset release, derives h and v from it, applies pix_in just after the falling edge and samples every output 1 ns later. Each expectation is therefore compared against the position the design must be at in that cycle. The bench runs two complete frames with reduced porch parameters, checks the per-line read count, and applies a reset in the middle of a line.

// File: rtl/vga565_pkg.sv
package vga565_pkg;

    typedef enum logic [1:0] {
        SEG_ACTIVE = 2'd0,
        SEG_FRONT  = 2'd1,
        SEG_SYNC   = 2'd2,
        SEG_BACK   = 2'd3
    } seg_e;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb888_t;

    // widen 5/6-bit fields by repeating their upper bits underneath
    function automatic rgb888_t expand565(input logic [15:0] p);
        rgb888_t c;
        c.r = {p[15:11], p[15:13]};
        c.g = {p[10:5],  p[10:9]};
        c.b = {p[4:0],   p[4:2]};
        return c;
    endfunction

endpackage

// File: rtl/vga565_seg_fsm.sv
module vga565_seg_fsm
    import vga565_pkg::*;
#(
    parameter int ACT_LEN   = 640,
    parameter int FRONT_LEN = 16,
    parameter int SYNC_LEN  = 96,
    parameter int BACK_LEN  = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic in_active,
    output logic in_sync,
    output logic front_first,
    output logic origin,
    output logic wrap
);

    localparam int MAX_AF  = (ACT_LEN > FRONT_LEN) ? ACT_LEN : FRONT_LEN;
    localparam int MAX_SB  = (SYNC_LEN > BACK_LEN) ? SYNC_LEN : BACK_LEN;
    localparam int MAX_LEN = (MAX_AF > MAX_SB) ? MAX_AF : MAX_SB;
    localparam int CW      = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

    seg_e          state_q;
    seg_e          state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_cnt;
    logic          seg_done;

    always_comb begin
        state_d  = SEG_ACTIVE;
        last_cnt = CW'(ACT_LEN - 1);
        unique case (state_q)
            SEG_ACTIVE: begin
                last_cnt = CW'(ACT_LEN - 1);
                state_d  = SEG_FRONT;
            end
            SEG_FRONT: begin
                last_cnt = CW'(FRONT_LEN - 1);
                state_d  = SEG_SYNC;
            end
            SEG_SYNC: begin
                last_cnt = CW'(SYNC_LEN - 1);
                state_d  = SEG_BACK;
            end
            SEG_BACK: begin
                last_cnt = CW'(BACK_LEN - 1);
                state_d  = SEG_ACTIVE;
            end
        endcase
    end

    assign seg_done = (cnt_q == last_cnt);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEG_ACTIVE;
            cnt_q   <= '0;
        end else if (step) begin
            if (seg_done) begin
                state_q <= state_d;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        in_active   = (state_q == SEG_ACTIVE);
        in_sync     = (state_q == SEG_SYNC);
        front_first = (state_q == SEG_FRONT) && (cnt_q == '0);
        origin      = (state_q == SEG_ACTIVE) && (cnt_q == '0);
        wrap        = step && (state_q == SEG_BACK) && seg_done;
    end

    AST_SEG_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_cnt); // R2

    AST_SEG_WRAP_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (state_q == SEG_ACTIVE) && (cnt_q == '0)); // R3

    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q) && $stable(state_q)); // R3

endmodule

// File: rtl/vga565_pixel_unpack.sv
module vga565_pixel_unpack
    import vga565_pkg::*;
(
    input  logic        de,
    input  logic [15:0] pix,
    output logic [7:0]  red,
    output logic [7:0]  green,
    output logic [7:0]  blue
);

    rgb888_t wide;

    always_comb begin
        wide = expand565(pix);
        if (de) begin
            red   = wide.r;
            green = wide.g;
            blue  = wide.b;
        end else begin
            red   = '0;
            green = '0;
            blue  = '0;
        end
    end

endmodule

// File: rtl/vga565_timing.sv
module vga565_timing
    import vga565_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int H_FRONT  = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BACK   = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FRONT  = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BACK   = 33
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] pix_in,
    output logic        pix_rd,
    output logic        buf_sel,
    output logic        line_adv,
    output logic        frame_start,
    output logic        hsync_n,
    output logic        vsync_n,
    output logic        de,
    output logic [7:0]  red,
    output logic [7:0]  green,
    output logic [7:0]  blue
);

    logic h_act, h_sync, h_front0, h_origin, h_wrap;
    logic v_act, v_sync, v_front0, v_origin, v_wrap;
    logic unused_vert;

    vga565_seg_fsm #(
        .ACT_LEN  (H_ACTIVE),
        .FRONT_LEN(H_FRONT),
        .SYNC_LEN (H_SYNC),
        .BACK_LEN (H_BACK)
    ) u_hseg (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (1'b1),
        .in_active  (h_act),
        .in_sync    (h_sync),
        .front_first(h_front0),
        .origin     (h_origin),
        .wrap       (h_wrap)
    );

    vga565_seg_fsm #(
        .ACT_LEN  (V_ACTIVE),
        .FRONT_LEN(V_FRONT),
        .SYNC_LEN (V_SYNC),
        .BACK_LEN (V_BACK)
    ) u_vseg (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (h_wrap),
        .in_active  (v_act),
        .in_sync    (v_sync),
        .front_first(v_front0),
        .origin     (v_origin),
        .wrap       (v_wrap)
    );

    assign unused_vert = v_front0 ^ v_wrap;

    always_comb begin
        de          = h_act & v_act;
        pix_rd      = h_act & v_act;
        hsync_n     = ~h_sync;
        vsync_n     = ~v_sync;
        line_adv    = h_front0 & v_act;
        frame_start = h_origin & v_origin;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_sel <= 1'b0;
        end else if (line_adv) begin
            buf_sel <= ~buf_sel;
        end
    end

    vga565_pixel_unpack u_unpack (
        .de   (de),
        .pix  (pix_in),
        .red  (red),
        .green(green),
        .blue (blue)
    );

    AST_HSYNC_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> !de); // R2

    AST_LINE_ADV_AFTER_DE: assert property (@(posedge clk) disable iff (!rst_n)
        line_adv |-> ($past(de) && !de)); // R7

    AST_LINE_ADV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        line_adv |=> !line_adv); // R7

    AST_BUF_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        line_adv |=> (buf_sel != $past(buf_sel))); // R8

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_adv |=> $stable(buf_sel)); // R8

    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (red == 8'd0 && green == 8'd0 && blue == 8'd0)); // R6

    AST_FRAME_START_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (de && hsync_n && vsync_n)); // R9

    AST_FRAME_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R9

endmodule

// File: tb/tb_vga565_timing.sv
module tb_vga565_timing;

    localparam int HA = 8, HF = 2, HS = 3, HB = 2;
    localparam int VA = 4, VF = 1, VS = 2, VB = 1;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int FT = HT * VT;

    // {pix565, red, green, blue}
    localparam logic [39:0] PIX_VEC [8] = '{
        40'hFFFF_FFFFFF,
        40'h0000_000000,
        40'hF800_FF0000,
        40'h07E0_00FF00,
        40'h001F_0000FF,
        40'h8410_848284,
        40'h7BEF_7B7D7B,
        40'hA54A_A5AA52
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pix_in = 16'h0;
    logic        pix_rd, buf_sel, line_adv, frame_start, hsync_n, vsync_n, de;
    logic [7:0]  red, green, blue;

    int tests = 0;
    int fails = 0;
    int t = 0;
    int rd_cnt = 0;
    logic exp_buf = 1'b0;

    always #4 clk = ~clk;

    vga565_timing #(
        .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
        .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .pix_rd(pix_rd),
        .buf_sel(buf_sel), .line_adv(line_adv), .frame_start(frame_start),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
        .red(red), .green(green), .blue(blue)
    );

    task automatic chk(input string tag, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s at t=%0d: got %0h expected %0h", tag, t, got, exp);
        end
    endtask

    // one cycle: drive, settle, compare against the position model
    task automatic step_check();
        int tt, h, v, idx;
        logic e_de, e_hs, e_vs, e_la, e_fs;
        logic [39:0] vec;
        tt  = t % FT;
        h   = tt % HT;
        v   = tt / HT;
        idx = t % 8;
        vec = PIX_VEC[idx];
        pix_in = vec[39:24];
        #1;
        e_de = (h < HA) && (v < VA);
        e_hs = !((h >= HA + HF) && (h < HA + HF + HS));
        e_vs = !((v >= VA + VF) && (v < VA + VF + VS));
        e_la = (h == HA) && (v < VA);
        e_fs = (tt == 0);
        chk("R2/R3 de", int'(de), int'(e_de));
        chk("R2 hsync_n", int'(hsync_n), int'(e_hs));
        chk("R3 vsync_n", int'(vsync_n), int'(e_vs));
        chk("R4 pix_rd", int'(pix_rd), int'(e_de));
        chk("R7 line_adv", int'(line_adv), int'(e_la));
        chk("R9 frame_start", int'(frame_start), int'(e_fs));
        chk("R8 buf_sel", int'(buf_sel), int'(exp_buf));
        if (e_de) begin
            chk("R5 colour", int'({red, green, blue}), int'(vec[23:0]));
        end else begin
            chk("R6 blank colour", int'({red, green, blue}), 0);
        end
        if (pix_rd) rd_cnt++;
        if (h == HT - 1) begin
            chk("R4 reads per line", rd_cnt, (v < VA) ? HA : 0);
            rd_cnt = 0;
        end
        if (e_la) exp_buf = ~exp_buf;
        @(negedge clk);
        t++;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step_check();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: state held during reset
        chk("R1 de in reset", int'(de), 1);
        chk("R1 hsync_n in reset", int'(hsync_n), 1);
        chk("R1 vsync_n in reset", int'(vsync_n), 1);
        chk("R1 line_adv in reset", int'(line_adv), 0);
        chk("R1 buf_sel in reset", int'(buf_sel), 0);
        @(negedge clk);
        rst_n = 1'b1;
        t = 0; rd_cnt = 0; exp_buf = 1'b0;
        // two full frames walking the colour table
        run(2 * FT);
        // run into the second line so buf_sel is 1, then reset mid-line
        run(20);
        chk("R8 buf_sel before reset", int'(buf_sel), 1);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R1 buf_sel after reset", int'(buf_sel), 0);
        chk("R1 frame_start after reset", int'(frame_start), 1);
        chk("R1 pix_rd after reset", int'(pix_rd), 1);
        chk("R1 hsync_n after reset", int'(hsync_n), 1);
        @(negedge clk);
        rst_n = 1'b1;
        t = 0; rd_cnt = 0; exp_buf = 1'b0;
        run(HT + 5);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 5000);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule